// File: doc/BRIEF.md
# Periodic Tick Timer

This block divides the system clock down to a fixed rate of fifty ticks per second, so one period lasts 20 ms. On every tick it raises a sticky ready flag and, when software has enabled it, emits a one-cycle interrupt request that an interrupt controller files under interrupt level 13.

The host reaches the block through a window of four addresses. The low two address bits pick the operation:

- Offset 0 always reads as zero.
- Offset 1 restarts the period.
- Offset 2 reads a small status word.
- Offset 3 takes a control write. That write restarts the period, loads the interrupt enable and can acknowledge the ready flag.

The terminal count comes from a clock-frequency parameter, so the same block serves any system clock.

Top module: `rtc_tick`

## Requirements
- R1: After reset the interrupt enable and the ready flag are 0, `irq` is 0, and the period counter starts from zero.
- R2: With no restarting access, a tick occurs every TC = CLK_HZ/TICK_HZ clock cycles, and the first tick falls TC cycles after reset or after the last restart.
- R3: On each tick `irq` pulses high for exactly one cycle if the interrupt enable was 1 before that edge; `irq` stays low while the enable is 0.
- R4: A tick sets the ready flag, and the flag remains 1 across any number of later ticks until it is cleared.
- R5: An access at offset 0 (address bits 00) returns zero on `rdata` and changes no state.
- R6: An access at offset 1 (address bits 01), read or write, restarts the period counter from zero.
- R7: A read at offset 2 (address bits 10) returns the ready flag in bit 3 and the interrupt enable in bit 0, with every other bit 0. `rdata` is zero whenever no such read is presented.
- R8: A write at offset 3 (address bits 11) restarts the period counter and loads the interrupt enable from `wdata` bit 0. It clears the ready flag if `wdata` bit 13 is 1 and leaves the flag unchanged otherwise.
- R9: A restarting access in the same cycle as the terminal count wins: no tick occurs, so there is no `irq` and no ready set.
- R10: A write at offset 2 and a read at offset 3 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Access strobe, one access per cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Offset within the four-address window |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational from the current access |
| irq | output | 1 | One-cycle tick interrupt request |

## Verification
The hardest case to reach is a restarting access that lands exactly on the terminal-count cycle. The bench brings it about by enabling the interrupt and then idling precisely TC-1 cycles before it issues an offset-1 access. It then checks that this tick is lost and that the next tick arrives a full period later. A second hard case is the difference between a sticky ready flag and a cleared one; the bench separates them by disabling the interrupt without acknowledging and by acknowledging with bit 13 set. The bench shrinks TC to ten cycles so that long random runs cross many period boundaries. A cycle model in the bench tracks every access and predicts `irq` and `rdata` on every cycle.

// File: rtl/rtc_tick.sv
module rtc_tick #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 50,
  parameter int DW      = 16,
  parameter int EN_BIT  = 0,
  parameter int CLR_BIT = 13,
  parameter int RDY_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int TC = CLK_HZ / TICK_HZ;
  localparam int CW = (TC > 2) ? $clog2(TC) : 1;

  logic [CW-1:0] cnt;
  logic          ready;
  logic          ien;

  wire restart = sel && (addr == 2'd1 || (wr && addr == 2'd3));
  wire ctl_wr  = sel && wr && addr == 2'd3;
  wire stat_rd = sel && !wr && addr == 2'd2;
  wire at_end  = cnt == CW'(TC - 1);
  wire tick    = at_end && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
      ien   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      cnt <= (restart || at_end) ? '0 : cnt + 1'b1;
      irq <= tick && ien;
      if (ctl_wr) ien <= wdata[EN_BIT];
      if (ctl_wr && wdata[CLR_BIT]) ready <= 1'b0;
      else if (tick) ready <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (stat_rd) begin
      rdata[RDY_BIT] = ready;
      rdata[EN_BIT]  = ien;
    end
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, wdata};
endmodule

// File: rtl/rtc_tick_chk.sv
module rtc_tick_chk #(
  parameter int DW = 16,
  parameter int CW = 4,
  parameter int TC = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          wr,
  input logic [1:0]    addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic [CW-1:0] cnt,
  input logic          ready,
  input logic          ien
);
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < TC);

  assert_irq_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ready);

  assert_irq_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ien));

  assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_ready_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> 32'($past(cnt)) == TC - 1);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && addr == 2'd1) |=> cnt == '0);

  assert_status_zero_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:4] == '0 && rdata[2:1] == 2'b00);

  assert_ready_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(sel && wr && addr == 2'd3 && wdata[13]));
endmodule

bind rtc_tick rtc_tick_chk #(.DW(DW), .CW(CW), .TC(TC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq(irq), .cnt(cnt), .ready(ready), .ien(ien)
);

// File: tb/rtc_tick_bench.sv
module rtc_tick_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HZ = 500;
  localparam int TC = HZ / 50;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n, sel, wr;
  logic [1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic irq;

  int total = 0, bad = 0;
  bit done = 0;

  int m_cnt;
  bit m_rdy, m_ien, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_tick #(.CLK_HZ(HZ), .TICK_HZ(50), .DW(DW)) u_rtc_tick (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int exp_rdata(bit s, bit w, logic [1:0] a);
    if (s && !w && a == 2'd2) return (int'(m_rdy) << 3) | int'(m_ien);
    return 0;
  endfunction

  task automatic model_step(bit s, bit w, logic [1:0] a, logic [DW-1:0] d);
    bit restart, tick;
    restart = s && (a == 2'd1 || (w && a == 2'd3));
    tick = !restart && m_cnt == TC - 1;
    m_irq = tick && m_ien;
    m_cnt = (restart || tick) ? 0 : m_cnt + 1;
    if (tick) m_rdy = 1;
    if (s && w && a == 2'd3) begin
      m_ien = d[0];
      if (d[13]) m_rdy = 0;
    end
  endtask

  task automatic cyc(input bit s, input bit w, input logic [1:0] a, input logic [DW-1:0] d);
    sel = s; wr = w; addr = a; wdata = d;
    #1;
    chk((s && !w && a == 2'd2) ? "R7 rdata" : "R5 rdata", int'(rdata), exp_rdata(s, w, a));
    @(posedge clk);
    model_step(s, w, a, d);
    @(negedge clk);
    chk("R3 irq", int'(irq), int'(m_irq));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 2'd0, '0);
  endtask

  task automatic status(input string tag, input int exp);
    sel = 1; wr = 0; addr = 2'd2; wdata = '0;
    #1;
    chk(tag, int'(rdata), exp);
    cyc(1, 0, 2'd2, '0);
  endtask

  task automatic cycles_to_irq(output int n);
    n = 0;
    for (int i = 1; i <= 3 * TC; i++) begin
      idle(1);
      if (irq && n == 0) n = i;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20231));
    rst_n = 0; sel = 0; wr = 0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_cnt = 0; m_rdy = 0; m_ien = 0; m_irq = 0;

    chk("R1 irq", int'(irq), 0);
    status("R1 status", 0);

    cyc(1, 1, 2'd3, 16'h0001);
    n = 0;
    for (int i = 1; i <= TC; i++) begin
      idle(1);
      if (irq && n == 0) n = i;
    end
    chk("R2 first tick", n, TC);
    idle(1);
    chk("R3 pulse width", int'(irq), 0);
    status("R7 ready+enable", 16'h0009);

    cyc(1, 1, 2'd3, 16'h0000);
    status("R8 disable keeps ready", 16'h0008);
    n = 0;
    for (int i = 0; i < 2 * TC + 2; i++) begin
      idle(1);
      if (irq) n++;
    end
    chk("R3 no irq when disabled", n, 0);
    status("R4 ready sticky", 16'h0008);

    cyc(1, 1, 2'd2, 16'h2001);
    status("R10 write at offset 2 ignored", 16'h0008);
    cyc(1, 0, 2'd3, '0);
    status("R10 read at offset 3 ignored", 16'h0008);

    cyc(1, 1, 2'd3, 16'h2000);
    status("R8 bit13 clears ready", 16'h0000);

    cyc(1, 1, 2'd3, 16'h0001);
    idle(TC - 1);
    cyc(1, 0, 2'd1, '0);
    chk("R9 restart beats terminal count", int'(irq), 0);
    status("R9 ready not set", 16'h0001);
    cycles_to_irq(n);
    chk("R6 period after restart", n, TC - 1);

    cyc(1, 1, 2'd3, 16'h0001);
    idle(3);
    cyc(1, 1, 2'd0, 16'hFFFF);
    cyc(1, 0, 2'd0, '0);
    cycles_to_irq(n);
    chk("R5 offset 0 keeps period", n, TC - 5);

    cyc(1, 1, 2'd3, 16'h0001);
    idle(4);
    cyc(1, 1, 2'd1, '0);
    cycles_to_irq(n);
    chk("R6 write at offset 1 restarts", n, TC);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 11) idle(1);
      else begin
        logic [DW-1:0] d;
        d = DW'($urandom);
        if ($urandom % 2) d[13] = 1'b0;
        cyc(1, 1'($urandom), 2'($urandom), d);
      end
    end
    status("R4 random end status", (int'(m_rdy) << 3) | int'(m_ien));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule